// File: doc/BRIEF.md
# Hardware Stack Engine

This block holds the 8-bit stack pointer of a small processor and carries out every stack transfer over a single byte-wide memory port. A control unit issues one command at a time. The commands are: push a byte, pop a byte, push or pull a status byte, save a return address for a subroutine call, restore it on return, load the pointer from an index value, and copy the pointer out with flag results. The stack sits in one fixed 256-byte page. The pointer wraps inside that page and never leaves it.

Each memory transfer takes one cycle. The memory answers reads combinationally, in the same cycle as the address. A command is accepted only while the engine is idle. Once the command is finished, `done` pulses for one cycle. In that same cycle any result output (`pop_byte`, `pc_next` with `pc_load`, `x_value` with `x_load`, `flag_n`/`flag_z`) shows its new value.

Command codes on `cmd_op` are: 0 no operation, 1 push byte, 2 pop byte, 3 push status, 4 pull status, 5 call, 6 return, 7 load pointer, 8 copy pointer out. All other codes are ignored.

Top module: `stk_engine`

## Requirements
- R1: Every stack access, read or write, uses address 0x0100 plus the current 8-bit pointer, so the address upper byte is always 0x01.
- R2: A push byte (code 1) writes `cmd_byte` at the current address in a single write cycle, and only then decrements the pointer.
- R3: A pop byte (code 2) first increments the pointer, then reads at the new address. The byte read appears on `pop_byte` together with `done`.
- R4: Load pointer (code 7) sets the pointer to `cmd_byte` and leaves `flag_n` and `flag_z` unchanged.
- R5: Copy pointer out (code 8) drives the pointer on `x_value` with a one-cycle `x_load`. `flag_n` takes pointer bit 7, and `flag_z` is 1 exactly when the pointer is zero.
- R6: A call (code 5) pushes `cmd_ret` minus one as two bytes, the high byte first and then the low byte. It then presents `cmd_target` on `pc_next` with `pc_load`.
- R7: A return (code 6) pops the low byte and then the high byte. It presents the 16-bit value plus one, modulo 65536, on `pc_next` with `pc_load`.
- R8: A push status (code 3) stores `cmd_byte` with bit 4 and bit 5 forced to 1.
- R9: A pull status (code 4) pops a byte and returns it on `pop_byte` with bit 4 forced to 0 and bit 5 forced to 1. The other six bits pass through unchanged.
- R10: The pointer wraps modulo 256: a decrement from 0x00 gives 0xFF, and an increment from 0xFF gives 0x00.
- R11: After reset the pointer is 0xFD, `busy`, `done`, `flag_n` and `flag_z` are 0, and no write is issued.
- R12: A command presented while `busy` is high is ignored. It causes no memory write and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 4 | Command code |
| cmd_byte | input | 8 | Byte to push, status to push, or new pointer |
| cmd_ret | input | 16 | Address of the instruction after a call |
| cmd_target | input | 16 | Call destination |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pop_byte | output | 8 | Last popped or pulled byte |
| pc_load | output | 1 | `pc_next` is to be loaded |
| pc_next | output | 16 | Next program counter for call or return |
| x_load | output | 1 | `x_value` is to be loaded |
| x_value | output | 8 | Pointer copy |
| flag_n | output | 1 | Negative flag of the pointer copy |
| flag_z | output | 1 | Zero flag of the pointer copy |
| sp_value | output | 8 | Current stack pointer |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| mem_rdata | input | 8 | Read data, valid in the address cycle |

## Verification
The hardest cases to reach are the pointer wrap edges and the mix of both byte orders with the off-by-one address rules. The pointer must sit at 0x00 or 0xFF when a multi-byte call or return starts. The bench reaches every pointer value directly through the load command. It then sweeps a push/pop pair over all 256 positions, and places calls and returns so that they straddle the wrap. A return address whose minus-one borrows into the high byte is included in those cases.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int DW = 8;
    localparam int AW = 16;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_PUSH  = 4'd1,
        OP_POP   = 4'd2,
        OP_PUSHF = 4'd3,
        OP_PULLF = 4'd4,
        OP_CALL  = 4'd5,
        OP_RET   = 4'd6,
        OP_LDSP  = 4'd7,
        OP_STSP  = 4'd8
    } stk_op_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_WR_HI = 3'd1,
        S_WR_LO = 3'd2,
        S_RD_LO = 3'd3,
        S_RD_HI = 3'd4
    } stk_state_e;

    typedef struct packed {
        stk_state_e    st;
        stk_op_e       kind;
        logic [DW-1:0] sp;
        logic [AW-1:0] wbuf;
        logic [DW-1:0] lo;
        logic [DW-1:0] pop_byte;
        logic [AW-1:0] pc;
        logic          pc_load;
        logic [DW-1:0] xv;
        logic          x_load;
        logic          n;
        logic          z;
        logic          done;
    } stk_regs_t;
endpackage

// File: rtl/stk_ptr_step.sv
module stk_ptr_step #(
    parameter int DW = 8,
    parameter logic [DW-1:0] PAGE = 8'h01
) (
    input  logic [DW-1:0]   sp,
    output logic [DW-1:0]   sp_inc,
    output logic [DW-1:0]   sp_dec,
    output logic [2*DW-1:0] addr
);
    // Pointer arithmetic is done in DW bits, so both steps wrap inside the page.
    always_comb begin
        sp_inc = sp + {{(DW-1){1'b0}}, 1'b1};
        sp_dec = sp - {{(DW-1){1'b0}}, 1'b1};
        addr   = {PAGE, sp};
    end
endmodule

// File: rtl/stk_psw_fmt.sv
module stk_psw_fmt #(
    parameter int DW    = 8,
    parameter int B_BIT = 4,
    parameter int U_BIT = 5
) (
    input  logic [DW-1:0] push_in,
    input  logic [DW-1:0] pull_in,
    output logic [DW-1:0] push_out,
    output logic [DW-1:0] pull_out
);
    localparam logic [DW-1:0] B_MASK = DW'(1) << B_BIT;
    localparam logic [DW-1:0] U_MASK = DW'(1) << U_BIT;

    // Pushed copy marks both the break and the unused position.
    // Pulled copy drops the break mark, since it is not a real flag.
    always_comb begin
        push_out = push_in | B_MASK | U_MASK;
        pull_out = (pull_in | U_MASK) & ~B_MASK;
    end
endmodule

// File: rtl/stk_nz_eval.sv
module stk_nz_eval #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] val,
    output logic          neg,
    output logic          zero
);
    always_comb begin
        neg  = val[DW-1];
        zero = (val == '0);
    end
endmodule

// File: rtl/stk_engine.sv
module stk_engine
    import stk_pkg::*;
#(
    parameter logic [DW-1:0] PAGE     = 8'h01,
    parameter logic [DW-1:0] SP_RESET = 8'hFD,
    parameter int            B_BIT    = 4,
    parameter int            U_BIT    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_op,
    input  logic [DW-1:0] cmd_byte,
    input  logic [AW-1:0] cmd_ret,
    input  logic [AW-1:0] cmd_target,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] pop_byte,
    output logic          pc_load,
    output logic [AW-1:0] pc_next,
    output logic          x_load,
    output logic [DW-1:0] x_value,
    output logic          flag_n,
    output logic          flag_z,
    output logic [DW-1:0] sp_value,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata
);
    localparam logic [AW-1:0] ONE16 = AW'(1);

    stk_regs_t r_q, r_d;

    logic [DW-1:0] sp_inc, sp_dec, psw_push, psw_pull;
    logic          nz_n, nz_z;

    stk_ptr_step #(.DW(DW), .PAGE(PAGE)) u_ptr (
        .sp     (r_q.sp),
        .sp_inc (sp_inc),
        .sp_dec (sp_dec),
        .addr   (mem_addr)
    );

    stk_psw_fmt #(.DW(DW), .B_BIT(B_BIT), .U_BIT(U_BIT)) u_psw (
        .push_in  (cmd_byte),
        .pull_in  (mem_rdata),
        .push_out (psw_push),
        .pull_out (psw_pull)
    );

    stk_nz_eval #(.DW(DW)) u_nz (
        .val  (r_q.sp),
        .neg  (nz_n),
        .zero (nz_z)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.pc_load = 1'b0;
        r_d.x_load  = 1'b0;
        mem_we      = 1'b0;
        mem_wdata   = '0;
        unique case (r_q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    r_d.kind = stk_op_e'(cmd_op);
                    case (cmd_op)
                        OP_PUSH: begin
                            r_d.wbuf = {{DW{1'b0}}, cmd_byte};
                            r_d.st   = S_WR_LO;
                        end
                        OP_PUSHF: begin
                            r_d.wbuf = {{DW{1'b0}}, psw_push};
                            r_d.st   = S_WR_LO;
                        end
                        OP_POP, OP_PULLF, OP_RET: begin
                            // pre-increment so the read cycle addresses straight from the register
                            r_d.sp = sp_inc;
                            r_d.st = S_RD_LO;
                        end
                        OP_CALL: begin
                            r_d.wbuf = cmd_ret - ONE16;
                            r_d.pc   = cmd_target;
                            r_d.st   = S_WR_HI;
                        end
                        OP_LDSP: begin
                            r_d.sp   = cmd_byte;
                            r_d.done = 1'b1;
                        end
                        OP_STSP: begin
                            r_d.xv     = r_q.sp;
                            r_d.x_load = 1'b1;
                            r_d.n      = nz_n;
                            r_d.z      = nz_z;
                            r_d.done   = 1'b1;
                        end
                        default: r_d.kind = r_q.kind;
                    endcase
                end
            end
            S_WR_HI: begin
                mem_we    = 1'b1;
                mem_wdata = r_q.wbuf[AW-1:DW];
                r_d.sp    = sp_dec;
                r_d.st    = S_WR_LO;
            end
            S_WR_LO: begin
                mem_we      = 1'b1;
                mem_wdata   = r_q.wbuf[DW-1:0];
                r_d.sp      = sp_dec;
                r_d.st      = S_IDLE;
                r_d.done    = 1'b1;
                r_d.pc_load = (r_q.kind == OP_CALL);
            end
            S_RD_LO: begin
                if (r_q.kind == OP_RET) begin
                    r_d.lo = mem_rdata;
                    r_d.sp = sp_inc;
                    r_d.st = S_RD_HI;
                end else begin
                    r_d.pop_byte = (r_q.kind == OP_PULLF) ? psw_pull : mem_rdata;
                    r_d.st       = S_IDLE;
                    r_d.done     = 1'b1;
                end
            end
            S_RD_HI: begin
                r_d.pc      = {mem_rdata, r_q.lo} + ONE16;
                r_d.pc_load = 1'b1;
                r_d.st      = S_IDLE;
                r_d.done    = 1'b1;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.kind <= OP_NOP;
            r_q.sp   <= SP_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != S_IDLE);
    assign done     = r_q.done;
    assign pop_byte = r_q.pop_byte;
    assign pc_load  = r_q.pc_load;
    assign pc_next  = r_q.pc;
    assign x_load   = r_q.x_load;
    assign x_value  = r_q.xv;
    assign flag_n   = r_q.n;
    assign flag_z   = r_q.z;
    assign sp_value = r_q.sp;

    // R2
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp_value == $past(sp_value) - 8'd1);

    // R10
    wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && sp_value == 8'h00) |=> sp_value == 8'hFF);

    // R4
    ldsp_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 4'd7) |=> ($stable(flag_n) && $stable(flag_z)));

    // R5
    stsp_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 4'd8) |=>
            (x_value == $past(sp_value) && flag_z == ($past(sp_value) == 8'h00) && x_load));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> ($stable(sp_value) && !mem_we));
endmodule

// File: tb/stk_engine_test.sv
module stk_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [7:0]  cmd_byte = 8'd0;
    logic [15:0] cmd_ret = 16'd0;
    logic [15:0] cmd_target = 16'd0;
    logic        busy, done, pc_load, x_load, flag_n, flag_z, mem_we;
    logic [7:0]  pop_byte, x_value, sp_value, mem_wdata, mem_rdata;
    logic [15:0] pc_next, mem_addr;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0]  mem [256];
    logic [15:0] wa0 = 0, wa1 = 0;
    logic [7:0]  wd0 = 0, wd1 = 0;
    int          wr_cnt = 0;
    bit          page_bad = 0;

    always #10 clk = ~clk;

    stk_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .cmd_ret(cmd_ret), .cmd_target(cmd_target),
        .busy(busy), .done(done), .pop_byte(pop_byte), .pc_load(pc_load),
        .pc_next(pc_next), .x_load(x_load), .x_value(x_value),
        .flag_n(flag_n), .flag_z(flag_z), .sp_value(sp_value),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wa1 <= wa0; wa0 <= mem_addr;
            wd1 <= wd0; wd0 <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
            if (mem_addr[15:8] != 8'h01) page_bad <= 1;
        end
        if (!busy && (mem_addr[15:8] != 8'h01)) page_bad <= 1;
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic [7:0] b, input logic [15:0] r, input logic [15:0] t);
        int n;
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_byte = b; cmd_ret = r; cmd_target = t;
        @(negedge clk);
        cmd_valid = 0;
        n = 0;
        while (!done && n < 20) begin @(negedge clk); n++; end
        if (!done) check(0, "timeout", 16'(n), 16'd0);
    endtask

    logic [7:0] exp8;

    initial begin
        foreach (mem[i]) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(sp_value == 8'hFD, "R11 sp", {8'h0, sp_value}, 16'h00FD);
        check(!busy && !done && !flag_n && !flag_z && !mem_we, "R11 outputs",
              {11'h0, busy, done, flag_n, flag_z, mem_we}, 16'h0);
        rst_n = 1;
        @(negedge clk);

        // R2 R3 R10 push/pop at every pointer value
        for (int s = 0; s < 256; s++) begin
            logic [7:0] v;
            v = 8'(s) ^ 8'h5A;
            run(4'd7, 8'(s), 0, 0);
            run(4'd1, v, 0, 0);
            check(wa0 == {8'h01, 8'(s)} && wd0 == v, "R2 write", wa0, {8'h01, 8'(s)});
            check(sp_value == 8'(s - 1), "R2 R10 dec", {8'h0, sp_value}, {8'h0, 8'(s - 1)});
            run(4'd2, 0, 0, 0);
            check(pop_byte == v, "R3 data", {8'h0, pop_byte}, {8'h0, v});
            check(sp_value == 8'(s), "R3 R10 inc", {8'h0, sp_value}, {8'h0, 8'(s)});
        end

        // R4: load keeps flags
        run(4'd7, 8'h00, 0, 0);
        run(4'd8, 0, 0, 0);
        run(4'd7, 8'h80, 0, 0);
        check(flag_z == 1 && flag_n == 0, "R4 flags kept", {14'h0, flag_n, flag_z}, 16'h1);
        check(sp_value == 8'h80, "R4 load", {8'h0, sp_value}, 16'h80);

        // R5 copy sweep
        for (int s = 0; s < 256; s++) begin
            run(4'd7, 8'(s), 0, 0);
            run(4'd8, 0, 0, 0);
            check(x_load && x_value == 8'(s), "R5 value", {8'h0, x_value}, 16'(s));
            check(flag_n == s[7] && flag_z == (s == 0), "R5 flags",
                  {14'h0, flag_n, flag_z}, {14'h0, s[7], s == 0});
        end

        // R6 call across wrap
        run(4'd7, 8'h00, 0, 0);
        run(4'd5, 0, 16'h1234, 16'hABCD);
        check(wa1 == 16'h0100 && wd1 == 8'h12, "R6 high first", {wa1[7:0], wd1}, 16'h0012);
        check(wa0 == 16'h01FF && wd0 == 8'h33, "R6 low second", {wa0[7:0], wd0}, 16'hFF33);
        check(pc_load && pc_next == 16'hABCD, "R6 target", pc_next, 16'hABCD);
        check(sp_value == 8'hFE, "R6 R10 sp", {8'h0, sp_value}, 16'hFE);
        // R7 return
        run(4'd6, 0, 0, 0);
        check(pc_load && pc_next == 16'h1234, "R7 pc", pc_next, 16'h1234);
        check(sp_value == 8'h00, "R7 R10 sp", {8'h0, sp_value}, 16'h0);

        // R6 borrow into high byte, R7 carry back
        run(4'd5, 0, 16'h1200, 16'h0040);
        check(wd1 == 8'h11 && wd0 == 8'hFF, "R6 borrow", {wd1, wd0}, 16'h11FF);
        run(4'd6, 0, 0, 0);
        check(pc_next == 16'h1200, "R7 carry", pc_next, 16'h1200);

        // R7 wrap 0xFFFF -> 0x0000
        run(4'd7, 8'h10, 0, 0);
        run(4'd1, 8'hFF, 0, 0);
        run(4'd1, 8'hFF, 0, 0);
        run(4'd6, 0, 0, 0);
        check(pc_next == 16'h0000 && pc_load, "R7 wrap", pc_next, 16'h0000);

        // R8 R9 status sweep
        for (int v = 0; v < 256; v++) begin
            run(4'd3, 8'(v), 0, 0);
            exp8 = 8'(v) | 8'h30;
            check(wd0 == exp8, "R8 pushed", {8'h0, wd0}, {8'h0, exp8});
            run(4'd4, 0, 0, 0);
            exp8 = (8'(v) | 8'h20) & 8'hEF;
            check(pop_byte == exp8, "R9 pulled", {8'h0, pop_byte}, {8'h0, exp8});
        end
        run(4'd1, 8'h10, 0, 0);
        run(4'd4, 0, 0, 0);
        check(pop_byte == 8'h20, "R9 raw break", {8'h0, pop_byte}, 16'h20);

        // R12 command while busy
        run(4'd7, 8'h40, 0, 0);
        begin
            int c0, n;
            c0 = wr_cnt;
            @(negedge clk);
            cmd_valid = 1; cmd_op = 4'd5; cmd_ret = 16'h5678; cmd_target = 16'h0;
            @(negedge clk);
            cmd_op = 4'd1; cmd_byte = 8'hEE;
            @(negedge clk);
            cmd_valid = 0; cmd_op = 0;
            n = 0;
            while (!done && n < 20) begin @(negedge clk); n++; end
            @(negedge clk);
            check(wr_cnt - c0 == 2, "R12 writes", 16'(wr_cnt - c0), 16'd2);
            check(sp_value == 8'h3E, "R12 sp", {8'h0, sp_value}, 16'h3E);
        end

        // R1 page
        check(!page_bad, "R1 page", {15'h0, page_bad}, 16'h0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule